// File: doc/BRIEF.md
# HDLC Frame Transmitter with Interframe Fill

This block turns bytes from a small on-chip queue into a bit-serial HDLC line signal, one bit per clock. Each queued byte carries two tags: one marks the final data byte of a frame, the other asks for the frame to be torn down in place of that byte. Framing is added by the block. It sends an opening flag, applies zero-bit insertion to the data and check fields, appends a complemented CRC-16 check sequence and sends a closing flag. The serial output has a separate drive enable so that the line can be shared.

Between frames the line carries one of four patterns, chosen by a two-bit mode input: steady ones, back-to-back flags, a repeating 0x7F go-ahead byte, or a transparent mode. In transparent mode, queued bytes are shifted out raw with no framing at all. A transmit enable switches the block on and off. Outside a frame the enable takes effect at once. Inside a frame the block finishes the closing flag or the abort before it releases the line.

Top module: `hdlc_tx_fill`

## Requirements
- R1: After reset, sdo_oe is low, sdo is high and fifo_full is low.
- R2: Out of frame, with an empty queue and tx_en high, the line carries 8-bit fill units sent LSB first without zero insertion. Mode 2'b00 sends 0xFF, mode 2'b01 sends 0x7E and mode 2'b11 sends 0x7F. A change of mode takes effect at the next unit boundary.
- R3: In modes 00, 01 and 11, a non-empty queue at a unit boundary starts a frame with a 0x7E flag. Data bytes follow LSB first. After five consecutive ones in the data or check fields, a single 0 is inserted.
- R4: After a byte tagged end-of-packet, the block sends the check sequence and then a 0x7E flag. The check sequence is the one's complement of a reflected CRC-16 (polynomial 0x8408 in shift-right form, preset 0xFFFF) taken over the data bits, low byte first.
- R5: A queued byte tagged abort is not sent. Eight raw ones are sent in its place and the frame ends.
- R6: If the queue is empty when a frame needs its next data byte, eight raw ones are sent and the line returns to fill.
- R7: If tx_en drops inside a frame, the frame runs to the end of its closing flag or abort with sdo_oe high. sdo_oe then goes low.
- R8: Outside a frame, tx_en low drives sdo_oe low on the next clock. This includes a raw byte left half-sent in transparent mode.
- R9: In mode 2'b10, queued bytes go out raw, LSB first, with no flags, no zero insertion, no check sequence and their tags ignored. An empty queue gives 0xFF units.
- R10: A one-cycle pulse on tag_eop_req or tag_abort_req stays pending until the next accepted write and is applied to that byte only. A pulse in the same cycle as the write also applies to it.
- R11: fifo_full is high when DEPTH entries are held. A write while fifo_full is high is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one line bit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write one byte into the queue |
| wr_data | input | 8 | Byte to queue |
| tag_eop_req | input | 1 | Mark the next written byte as end of packet |
| tag_abort_req | input | 1 | Mark the next written byte as abort |
| fifo_full | output | 1 | Queue holds DEPTH entries |
| tx_en | input | 1 | Transmit enable |
| fill_mode | input | 2 | Interframe fill / transparent select |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Drive enable for sdo |

## Verification
The bench targets a data byte of 0xFF and check-sequence bytes that build runs of five ones. A design that counted ones wrongly, or reset the count at byte edges, would drop or misplace an inserted zero and shift every later bit. It drops tx_en in the middle of a frame and in the middle of a transparent byte. A design that ignored the packet boundary would cut the frame short, and one that waited in transparent mode would keep driving the line. It pulses the tag requests one cycle ahead of a write, writes into a full queue and lets the queue underrun mid-frame. Each of these is a place where a stale tag, a stored overflow byte or a missing abort would show on the line.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;

  localparam int BYTE_W = 8;
  localparam int CRC_W  = 16;

  localparam logic [BYTE_W-1:0] FLAG_BYTE = 8'h7E;
  localparam logic [BYTE_W-1:0] ONES_BYTE = 8'hFF;
  localparam logic [BYTE_W-1:0] GA_BYTE   = 8'h7F;
  localparam logic [CRC_W-1:0]  CRC_PRESET = 16'hFFFF;
  localparam logic [CRC_W-1:0]  CRC_POLY_R = 16'h8408;

  typedef enum logic [1:0] {
    FILL_ONES    = 2'b00,
    FILL_FLAGS   = 2'b01,
    FILL_RAW     = 2'b10,
    FILL_GOAHEAD = 2'b11
  } fill_mode_e;

  typedef enum logic [2:0] {
    FS_OUT,
    FS_BODY,
    FS_FCS_LO,
    FS_FCS_HI,
    FS_CLOSE,
    FS_TERM
  } frame_st_e;

  typedef struct packed {
    logic              abort;
    logic              eop;
    logic [BYTE_W-1:0] data;
  } tx_entry_t;

  function automatic logic [CRC_W-1:0] crc_bit(input logic [CRC_W-1:0] c, input logic b);
    logic fb;
    fb = c[0] ^ b;
    return fb ? ((c >> 1) ^ CRC_POLY_R) : (c >> 1);
  endfunction

  function automatic logic [BYTE_W-1:0] fill_byte(input fill_mode_e m);
    case (m)
      FILL_FLAGS:   return FLAG_BYTE;
      FILL_GOAHEAD: return GA_BYTE;
      default:      return ONES_BYTE;
    endcase
  endfunction

endpackage

// File: rtl/hdlc_tx_fifo.sv
module hdlc_tx_fifo
  import hdlc_tx_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              tag_eop_req,
  input  logic              tag_abort_req,
  input  logic              pop,
  output tx_entry_t         rd_entry,
  output logic              empty,
  output logic              full,
  output logic [CW-1:0]     level
);

  tx_entry_t       mem_q [DEPTH];
  logic [AW-1:0]   wr_ptr_q, wr_ptr_n, rd_ptr_q, rd_ptr_n;
  logic [CW-1:0]   cnt_q, cnt_n;
  logic            eop_pend_q, eop_pend_n, abt_pend_q, abt_pend_n;
  logic            push, do_pop;
  tx_entry_t       new_entry;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : AW'(p + 1'b1);
  endfunction

  assign full     = (cnt_q == CW'(DEPTH));
  assign empty    = (cnt_q == '0);
  assign level    = cnt_q;
  assign rd_entry = mem_q[rd_ptr_q];
  assign push     = wr_en && !full;
  assign do_pop   = pop && !empty;

  always_comb begin
    new_entry.data  = wr_data;
    new_entry.eop   = eop_pend_q | tag_eop_req;
    new_entry.abort = abt_pend_q | tag_abort_req;
    wr_ptr_n   = push   ? bump(wr_ptr_q) : wr_ptr_q;
    rd_ptr_n   = do_pop ? bump(rd_ptr_q) : rd_ptr_q;
    cnt_n      = CW'(cnt_q + CW'(push) - CW'(do_pop));
    eop_pend_n = push ? 1'b0 : (eop_pend_q | tag_eop_req);
    abt_pend_n = push ? 1'b0 : (abt_pend_q | tag_abort_req);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q   <= '0;
      rd_ptr_q   <= '0;
      cnt_q      <= '0;
      eop_pend_q <= 1'b0;
      abt_pend_q <= 1'b0;
    end else begin
      wr_ptr_q   <= wr_ptr_n;
      rd_ptr_q   <= rd_ptr_n;
      cnt_q      <= cnt_n;
      eop_pend_q <= eop_pend_n;
      abt_pend_q <= abt_pend_n;
    end
  end

  // storage has no reset; only entries covered by cnt_q are ever read
  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (push && (wr_ptr_q == AW'(i))) mem_q[i] <= new_entry;
    end
  end

endmodule

// File: rtl/hdlc_tx_serial.sv
module hdlc_tx_serial
  import hdlc_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_en,
  input  fill_mode_e mode,
  input  logic       q_empty,
  input  tx_entry_t  q_entry,
  output logic       q_pop,
  output logic       sdo,
  output logic       sdo_oe,
  output logic       frame_busy,
  output logic       stuff_due
);

  localparam int BCW = $clog2(BYTE_W + 1);
  localparam int OCW = 3;
  localparam logic [OCW-1:0] RUN_MAX = 3'd5;

  frame_st_e          fs_q, fs_n;
  logic [BYTE_W-1:0]  sh_q, sh_n;
  logic [BCW-1:0]     bcnt_q, bcnt_n;
  logic               stf_q, stf_n, crcu_q, crcu_n;
  logic [OCW-1:0]     ones_q, ones_n;
  logic [CRC_W-1:0]   crc_q, crc_n;
  logic               sdo_q, sdo_n, oe_q, oe_n;

  logic               outside, cur_bit, cur_stf, cur_crc;
  logic               ld_stf, ld_crc;
  logic [BYTE_W-1:0]  ld_byte;
  frame_st_e          sel_st;

  assign outside    = (fs_q == FS_OUT) || ((fs_q == FS_TERM) && (bcnt_q == '0));
  assign stuff_due  = (ones_q == RUN_MAX);
  assign frame_busy = !outside;
  assign sdo        = sdo_q;
  assign sdo_oe     = oe_q;
  assign sel_st     = outside ? FS_OUT : fs_q;

  // unit selection at a boundary
  always_comb begin
    ld_byte = ONES_BYTE;
    ld_stf  = 1'b0;
    ld_crc  = 1'b0;
    q_pop   = 1'b0;
    fs_n    = fs_q;
    crc_n   = crc_q;
    if (!stuff_due && !(outside && !tx_en) && (bcnt_q == '0)) begin
      unique case (sel_st)
        FS_OUT: begin
          fs_n = FS_OUT;
          if (mode == FILL_RAW) begin
            if (!q_empty) begin
              q_pop   = 1'b1;
              ld_byte = q_entry.data;
            end
          end else if (!q_empty) begin
            ld_byte = FLAG_BYTE;
            crc_n   = CRC_PRESET;
            fs_n    = FS_BODY;
          end else begin
            ld_byte = fill_byte(mode);
          end
        end
        FS_BODY: begin
          if (q_empty) begin
            fs_n = FS_TERM;
          end else begin
            q_pop = 1'b1;
            if (q_entry.abort) begin
              fs_n = FS_TERM;
            end else begin
              ld_byte = q_entry.data;
              ld_stf  = 1'b1;
              ld_crc  = 1'b1;
              fs_n    = q_entry.eop ? FS_FCS_LO : FS_BODY;
            end
          end
        end
        FS_FCS_LO: begin
          ld_byte = ~crc_q[7:0];
          ld_stf  = 1'b1;
          fs_n    = FS_FCS_HI;
        end
        FS_FCS_HI: begin
          ld_byte = ~crc_q[15:8];
          ld_stf  = 1'b1;
          fs_n    = FS_CLOSE;
        end
        FS_CLOSE: begin
          ld_byte = FLAG_BYTE;
          fs_n    = FS_TERM;
        end
        default: fs_n = FS_OUT;
      endcase
    end
  end

  // bit emission
  always_comb begin
    sh_n    = sh_q;
    bcnt_n  = bcnt_q;
    stf_n   = stf_q;
    crcu_n  = crcu_q;
    ones_n  = ones_q;
    sdo_n   = sdo_q;
    oe_n    = oe_q;
    cur_bit = 1'b1;
    cur_stf = 1'b0;
    cur_crc = 1'b0;
    if (stuff_due) begin
      sdo_n  = 1'b0;
      oe_n   = 1'b1;
      ones_n = '0;
    end else if (outside && !tx_en) begin
      sdo_n  = 1'b1;
      oe_n   = 1'b0;
      bcnt_n = '0;
    end else begin
      if (bcnt_q == '0) begin
        cur_bit = ld_byte[0];
        cur_stf = ld_stf;
        cur_crc = ld_crc;
        sh_n    = {1'b0, ld_byte[BYTE_W-1:1]};
        bcnt_n  = BCW'(BYTE_W - 1);
        stf_n   = ld_stf;
        crcu_n  = ld_crc;
      end else begin
        cur_bit = sh_q[0];
        cur_stf = stf_q;
        cur_crc = crcu_q;
        sh_n    = sh_q >> 1;
        bcnt_n  = BCW'(bcnt_q - 1'b1);
      end
      sdo_n  = cur_bit;
      oe_n   = 1'b1;
      ones_n = (cur_stf && cur_bit) ? OCW'(ones_q + 1'b1) : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_q   <= FS_OUT;
      sh_q   <= '0;
      bcnt_q <= '0;
      stf_q  <= 1'b0;
      crcu_q <= 1'b0;
      ones_q <= '0;
      crc_q  <= CRC_PRESET;
      sdo_q  <= 1'b1;
      oe_q   <= 1'b0;
    end else begin
      fs_q   <= (outside && !tx_en && !stuff_due) ? FS_OUT : fs_n;
      sh_q   <= sh_n;
      bcnt_q <= bcnt_n;
      stf_q  <= stf_n;
      crcu_q <= crcu_n;
      ones_q <= ones_n;
      crc_q  <= cur_crc ? crc_bit(crc_n, cur_bit) : crc_n;
      sdo_q  <= sdo_n;
      oe_q   <= oe_n;
    end
  end

endmodule

// File: rtl/hdlc_tx_fill.sv
module hdlc_tx_fill
  import hdlc_tx_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [7:0]  wr_data,
  input  logic        tag_eop_req,
  input  logic        tag_abort_req,
  output logic        fifo_full,
  input  logic        tx_en,
  input  logic [1:0]  fill_mode,
  output logic        sdo,
  output logic        sdo_oe
);

  tx_entry_t     q_entry;
  logic          q_empty, fifo_pop, frame_busy, stuff_due;
  logic [CW-1:0] fifo_level;

  hdlc_tx_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (wr_en),
    .wr_data       (wr_data),
    .tag_eop_req   (tag_eop_req),
    .tag_abort_req (tag_abort_req),
    .pop           (fifo_pop),
    .rd_entry      (q_entry),
    .empty         (q_empty),
    .full          (fifo_full),
    .level         (fifo_level)
  );

  hdlc_tx_serial u_ser (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_en      (tx_en),
    .mode       (fill_mode_e'(fill_mode)),
    .q_empty    (q_empty),
    .q_entry    (q_entry),
    .q_pop      (fifo_pop),
    .sdo        (sdo),
    .sdo_oe     (sdo_oe),
    .frame_busy (frame_busy),
    .stuff_due  (stuff_due)
  );

endmodule

// File: rtl/hdlc_tx_fill_chk.sv
module hdlc_tx_fill_chk #(
  parameter int DEPTH = 4,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tx_en,
  input logic          sdo,
  input logic          sdo_oe,
  input logic          frame_busy,
  input logic          stuff_due,
  input logic          fifo_pop,
  input logic [CW-1:0] fifo_level
);

  // R3: a run of five stuffed ones is followed by a driven zero
  assert_stuff_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    stuff_due |=> (sdo_oe && !sdo));

  // R7: the line stays driven while a frame is still open
  assert_frame_drives_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_busy |=> sdo_oe);

  // R8: outside a frame, a low enable releases the line on the next clock
  assert_idle_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_busy && !tx_en) |=> !sdo_oe);

  // R11: a full queue with no read stays full (extra writes are dropped)
  assert_full_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ((fifo_level == CW'(DEPTH)) && !fifo_pop) |=> (fifo_level == CW'(DEPTH)));

  // R11: occupancy never exceeds the depth
  assert_level_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_level <= CW'(DEPTH));

endmodule

bind hdlc_tx_fill hdlc_tx_fill_chk #(.DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tx_en      (tx_en),
  .sdo        (sdo),
  .sdo_oe     (sdo_oe),
  .frame_busy (frame_busy),
  .stuff_due  (stuff_due),
  .fifo_pop   (fifo_pop),
  .fifo_level (fifo_level)
);

// File: tb/hdlc_tx_fill_tb.sv
module hdlc_tx_fill_tb;

  localparam int DEPTH = 4;
  localparam int S_OUT = 0, S_BODY = 1, S_FLO = 2, S_FHI = 3, S_CLO = 4, S_TERM = 5;

  logic       clk, rst_n, wr_en, tag_eop_req, tag_abort_req, tx_en;
  logic [7:0] wr_data;
  logic [1:0] fill_mode;
  logic       fifo_full, sdo, sdo_oe;

  int checks = 0;
  int failures = 0;
  string cur_req = "R1";
  bit running = 0;
  bit done = 0;

  hdlc_tx_fill #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .tag_eop_req(tag_eop_req), .tag_abort_req(tag_abort_req),
    .fifo_full(fifo_full), .tx_en(tx_en), .fill_mode(fill_mode),
    .sdo(sdo), .sdo_oe(sdo_oe)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // ---------------- reference model ----------------
  int fq[$];
  int bq[$];
  int m_fs, m_ones, m_crc, m_ent, m_pre, m_e, m_b;
  bit m_sdo, m_oe, m_full, m_pe, m_pa, m_outside;

  function automatic void put_unit(int byt, bit st, bit cu);
    for (int i = 0; i < 8; i++) bq.push_back(((byt >> i) & 1) | (int'(st) << 1) | (int'(cu) << 2));
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      fq.delete(); bq.delete();
      m_fs = S_OUT; m_ones = 0; m_crc = 16'hFFFF;
      m_sdo = 1; m_oe = 0; m_full = 0; m_pe = 0; m_pa = 0;
    end else begin
      m_pre = fq.size();
      m_outside = (m_fs == S_OUT) || (m_fs == S_TERM && bq.size() == 0);
      if (m_ones == 5) begin
        m_sdo = 0; m_oe = 1; m_ones = 0;
      end else if (m_outside && !tx_en) begin
        m_oe = 0; m_sdo = 1; bq.delete(); m_fs = S_OUT;
      end else begin
        if (bq.size() == 0) begin
          if (m_outside) begin
            m_fs = S_OUT;
            if (fill_mode == 2'b10) begin
              if (fq.size() > 0) begin m_ent = fq.pop_front(); put_unit(m_ent & 255, 0, 0); end
              else put_unit(255, 0, 0);
            end else if (fq.size() > 0) begin
              put_unit(126, 0, 0); m_crc = 16'hFFFF; m_fs = S_BODY;
            end else begin
              put_unit(fill_mode == 2'b00 ? 255 : (fill_mode == 2'b01 ? 126 : 127), 0, 0);
            end
          end else if (m_fs == S_BODY) begin
            if (fq.size() == 0) begin put_unit(255, 0, 0); m_fs = S_TERM; end
            else begin
              m_ent = fq.pop_front();
              if (m_ent & 512) begin put_unit(255, 0, 0); m_fs = S_TERM; end
              else begin
                put_unit(m_ent & 255, 1, 1);
                m_fs = (m_ent & 256) ? S_FLO : S_BODY;
              end
            end
          end else if (m_fs == S_FLO) begin
            put_unit((~m_crc) & 255, 1, 0); m_fs = S_FHI;
          end else if (m_fs == S_FHI) begin
            put_unit(((~m_crc) >> 8) & 255, 1, 0); m_fs = S_CLO;
          end else begin
            put_unit(126, 0, 0); m_fs = S_TERM;
          end
        end
        m_e = bq.pop_front();
        m_b = m_e & 1;
        if (m_e & 2) m_ones = m_b ? m_ones + 1 : 0; else m_ones = 0;
        if (m_e & 4) begin
          if (((m_crc ^ m_b) & 1) != 0) m_crc = (m_crc >> 1) ^ 16'h8408;
          else m_crc = m_crc >> 1;
        end
        m_sdo = m_b[0]; m_oe = 1;
      end
      if (wr_en && m_pre < DEPTH) begin
        fq.push_back(int'(wr_data) | (int'(m_pe | tag_eop_req) << 8) | (int'(m_pa | tag_abort_req) << 9));
        m_pe = 0; m_pa = 0;
      end else begin
        m_pe = m_pe | tag_eop_req; m_pa = m_pa | tag_abort_req;
      end
      m_full = (fq.size() == DEPTH);
    end
  end

  // ---------------- per-cycle comparison ----------------
  always @(negedge clk) begin
    if (running && rst_n) begin
      checks++;
      if (sdo_oe !== m_oe || (m_oe && sdo !== m_sdo) || fifo_full !== m_full) begin
        failures++;
        $display("FAIL %s t=%0t oe/sdo/full actual=%b%b%b expected=%b%b%b",
                 cur_req, $time, sdo_oe, sdo, fifo_full, m_oe, m_sdo, m_full);
      end
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [7:0] d, bit eop, bit ab);
    wr_en = 1; wr_data = d; tag_eop_req = eop; tag_abort_req = ab;
    @(negedge clk);
    wr_en = 0; tag_eop_req = 0; tag_abort_req = 0;
  endtask

  task automatic check1(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    summary();
  end

  initial begin
    rst_n = 0; wr_en = 0; wr_data = 0; tag_eop_req = 0; tag_abort_req = 0;
    tx_en = 0; fill_mode = 2'b00;
    step(3);
    // R1: reset state
    check1("R1 sdo_oe", sdo_oe, 1'b0);
    check1("R1 sdo", sdo, 1'b1);
    check1("R1 fifo_full", fifo_full, 1'b0);
    rst_n = 1;
    running = 1;
    step(2);

    // R2: fill patterns, mode changed mid-unit
    cur_req = "R2"; tx_en = 1; fill_mode = 2'b00; step(21);
    fill_mode = 2'b01; step(27);
    fill_mode = 2'b11; step(29);

    // R3 / R4 / R10: frame with stuffing, eop request pulsed one cycle early
    cur_req = "R3/R4/R10"; fill_mode = 2'b01;
    wr(8'h12, 0, 0); wr(8'hFF, 0, 0);
    tag_eop_req = 1; step(1); tag_eop_req = 0;
    wr(8'h3E, 0, 0);
    step(90);

    // R5: abort tag replaces byte
    cur_req = "R5"; fill_mode = 2'b11;
    wr(8'h55, 0, 0); wr(8'hAA, 0, 1);
    step(50);

    // R6 / R10: underrun, pending tags must be clear
    cur_req = "R6/R10"; fill_mode = 2'b00;
    wr(8'h81, 0, 0);
    step(50);

    // R7: disable inside a frame
    cur_req = "R7"; fill_mode = 2'b01;
    wr(8'hF8, 0, 0); wr(8'h1F, 0, 0); wr(8'h7E, 0, 0); wr(8'hC3, 1, 0);
    step(15); tx_en = 0; step(90);
    check1("R7 released", sdo_oe, 1'b0);

    // R9 / R8: transparent bytes, tags ignored, then disable mid-byte
    cur_req = "R9"; fill_mode = 2'b10; tx_en = 1;
    wr(8'hA5, 1, 0); wr(8'hFF, 0, 1); wr(8'h3C, 0, 0);
    step(36);
    cur_req = "R8"; step(3); tx_en = 0; step(1);
    check1("R8 quick release", sdo_oe, 1'b0);
    step(5);

    // R11: fill queue while disabled, overflow write dropped
    cur_req = "R11"; fill_mode = 2'b01;
    wr(8'h01, 0, 0); wr(8'hBF, 0, 0); wr(8'hFE, 0, 0); wr(8'h40, 1, 0);
    check1("R11 full", fifo_full, 1'b1);
    wr(8'h99, 0, 0);
    check1("R11 still full", fifo_full, 1'b1);
    step(3); tx_en = 1;
    step(100);
    check1("R11 drained", fifo_full, 1'b0);

    running = 0;
    summary();
  end

endmodule